// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block scales a two-channel signed PCM stream by a shared digital gain so that a mute request fades the audio out gradually and releasing it fades the audio back in, with no click. The gain is an unsigned counter that moves one step per frame strobe. It moves toward zero while the mute request is high and toward unity while it is low. Because each strobe moves it by exactly one step, a reversal partway through a fade continues from the level already reached and retraces the same slope.

At unity the samples pass through unchanged. Below unity each sample is multiplied by the gain and divided by 2^GAIN_W, rounding toward zero, so the fully muted output is exactly zero. A two-bit status tells the surrounding logic whether the path is at unity, fading, or fully muted.

Top module: `soft_mute_ramp`

## Requirements
- R1: While rst_ni is low, left_o and right_o are 0 and state_o is 0 (unity). The gain resets to unity (2^GAIN_W-1).
- R2: The gain changes only on a clock edge where frame_i is high. Without strobes it holds its value whatever mute_i does.
- R3: On a strobe with mute_i high and gain above zero, the gain decreases by one. From unity it reaches zero after 2^GAIN_W-1 strobes (1023 with the defaults).
- R4: On a strobe with mute_i low and gain below unity, the gain increases by one. From zero it reaches unity after 2^GAIN_W-1 strobes.
- R5: mute_i is level-sensitive. While it stays high, further strobes leave the gain at zero.
- R6: If mute_i is released during a fade-out, the gain climbs back from its current value. Unity returns after as many strobes as the fade-out had taken.
- R7: If mute_i is raised during a fade-in, the gain falls again from its current value at one step per strobe.
- R8: At unity, each output equals its input from the previous clock edge, bit for bit, including full-scale negative.
- R9: Below unity, each output is (input × gain) / 2^GAIN_W rounded toward zero, with one clock of latency. With gain 511, 1000 gives 499 and -1000 gives -499.
- R10: At gain zero, both outputs are exactly 0 for any input, including -2^(DATA_W-1).
- R11: state_o encodes 0 for unity, 1 for fading (gain strictly between the ends) and 2 for fully muted. It follows the gain with no added latency.
- R12: Both channels use the same gain, and each channel's output depends only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| frame_i | input | 1 | one-cycle frame strobe; gain steps on it |
| mute_i | input | 1 | mute request, level-sensitive |
| left_i | input | DATA_W | left sample, two's complement |
| right_i | input | DATA_W | right sample, two's complement |
| left_o | output | DATA_W | scaled left sample, registered |
| right_o | output | DATA_W | scaled right sample, registered |
| state_o | output | 2 | 0 unity, 1 fading, 2 muted |

## Verification
Two functions meet on the same edge: the gain step triggered by a frame strobe, and the scaling of the sample captured at that edge. The sample registered on a strobe edge must use the gain from before the step, and only the next edge shows the new gain. The bench drives a fixed probe sample of 1024, which reads the gain back directly, and samples one cycle after each strobe so that it sees the settled value. A second meeting point is a change of mute direction at the strobe where it takes effect. This is provoked by flipping mute_i at intermediate gains in both directions, and judged by the strobe count needed to reach each end.

// File: rtl/soft_mute_pkg.sv
package soft_mute_pkg;
  typedef enum logic [1:0] {
    ST_UNITY = 2'd0,
    ST_RAMP  = 2'd1,
    ST_MUTED = 2'd2
  } mute_state_e;
endpackage

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl #(
  parameter int GAIN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              mute_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] GainMax = '1;

  logic [GAIN_W-1:0] gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (frame_i) begin
      if (mute_i && gain_q != '0)       gain_d = gain_q - 1'b1;
      else if (!mute_i && gain_q != GainMax) gain_d = gain_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gain_q <= GainMax;
    else         gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [DATA_W-1:0] sample_o
);
  localparam int PW = DATA_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GainMax = '1;
  localparam logic signed [PW-1:0] Bias = PW'((64'd1 << GAIN_W) - 64'd1);

  logic signed [PW-1:0] prod, sum;
  logic [DATA_W-1:0] scaled, next;

  always_comb begin
    prod = $signed({{(GAIN_W+1){sample_i[DATA_W-1]}}, sample_i}) *
           $signed({{(DATA_W+1){1'b0}}, gain_i});
    // bias negatives so the arithmetic shift truncates toward zero
    sum    = prod[PW-1] ? prod + Bias : prod;
    scaled = sum[GAIN_W +: DATA_W];
    next   = (gain_i == GainMax) ? sample_i : scaled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= '0;
    else         sample_o <= next;
  end
endmodule

// File: rtl/smr_status.sv
module smr_status #(
  parameter int GAIN_W = 10
) (
  input  logic [GAIN_W-1:0]            gain_i,
  output soft_mute_pkg::mute_state_e   state_o
);
  import soft_mute_pkg::*;
  localparam logic [GAIN_W-1:0] GainMax = '1;

  always_comb begin
    if (gain_i == '0)          state_o = ST_MUTED;
    else if (gain_i == GainMax) state_o = ST_UNITY;
    else                        state_o = ST_RAMP;
  end
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              mute_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic [1:0]        state_o
);
  import soft_mute_pkg::*;
  localparam int NumCh = 2;

  logic [GAIN_W-1:0] gain_q;
  logic [NumCh-1:0][DATA_W-1:0] ch_in, ch_out;
  mute_state_e st;

  smr_gain_ctrl #(.GAIN_W(GAIN_W)) i_gain (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i),
    .mute_i(mute_i), .gain_o(gain_q)
  );

  assign ch_in = {right_i, left_i};

  for (genvar c = 0; c < NumCh; c++) begin : g_ch
    smr_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_scale (
      .clk_i(clk_i), .rst_ni(rst_ni), .gain_i(gain_q),
      .sample_i(ch_in[c]), .sample_o(ch_out[c])
    );
  end

  smr_status #(.GAIN_W(GAIN_W)) i_status (.gain_i(gain_q), .state_o(st));

  assign left_o  = ch_out[0];
  assign right_o = ch_out[1];
  assign state_o = st;
endmodule

// File: rtl/soft_mute_ramp_chk.sv
module soft_mute_ramp_chk #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic              mute_i,
  input logic [GAIN_W-1:0] gain_i,
  input logic [DATA_W-1:0] left_i,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic [1:0]        state_i
);
  localparam logic [GAIN_W-1:0] GainMax = '1;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(gain_i));
  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_i && gain_i != '0) |=> gain_i == $past(gain_i) - 1'b1);
  assert_step_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !mute_i && gain_i != GainMax) |=> gain_i == $past(gain_i) + 1'b1);
  assert_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_i && gain_i == '0) |=> gain_i == '0);
  assert_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_i == GainMax) |=> left_o == $past(left_i));
  assert_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_i == '0) |=> (left_o == '0 && right_o == '0));
  assert_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && mute_i && gain_i == GainMax) |=> state_i == 2'd1);
endmodule

bind soft_mute_ramp soft_mute_ramp_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .mute_i(mute_i),
  .gain_i(gain_q), .left_i(left_i), .left_o(left_o), .right_o(right_o),
  .state_i(state_o)
);

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
  localparam int DATA_W = 24;
  localparam int GAIN_W = 10;
  localparam int GMAX = (1 << GAIN_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, frame = 1'b0, mute = 1'b0;
  logic [DATA_W-1:0] l_in = '0, r_in = '0, l_out, r_out;
  logic [1:0] st;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  soft_mute_ramp #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_soft_mute_ramp (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .mute_i(mute),
    .left_i(l_in), .right_i(r_in), .left_o(l_out), .right_o(r_out),
    .state_o(st)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      frame = 1'b1;
      @(negedge clk);
      frame = 1'b0;
      @(negedge clk);
    end
  endtask

  // probe of 1024 reads back the gain; unity passes 1024 through
  task automatic read_gain(output int g);
    l_in = DATA_W'(1024);
    @(negedge clk);
    g = (int'($signed(l_out)) == 1024) ? GMAX : int'($signed(l_out));
  endtask

  task automatic t_reset;
    check("R1 left", int'(l_out), 0);
    check("R1 right", int'(r_out), 0);
    check("R1 state", int'(st), 0);
  endtask

  task automatic t_unity;
    l_in = DATA_W'(-8388608);
    r_in = DATA_W'(123457);
    @(negedge clk);
    check("R8 left full-scale neg", int'($signed(l_out)), -8388608);
    check("R12 right pass", int'($signed(r_out)), 123457);
  endtask

  task automatic t_no_strobe;
    int g;
    mute = 1'b1;
    repeat (20) @(negedge clk);
    read_gain(g);
    check("R2 gain held", g, GMAX);
    check("R2 state", int'(st), 0);
  endtask

  task automatic t_down;
    int g;
    strobes(1);
    read_gain(g);
    check("R3 first step", g, GMAX - 1);
    check("R11 ramping", int'(st), 1);
    strobes(511);
    read_gain(g);
    check("R3 half", g, 511);
    l_in = DATA_W'(1000);
    r_in = DATA_W'(-1000);
    @(negedge clk);
    check("R9 pos", int'($signed(l_out)), 499);
    check("R9 neg", int'($signed(r_out)), -499);
    l_in = DATA_W'(-1001);
    r_in = DATA_W'(2048);
    @(negedge clk);
    check("R9 neg round", int'($signed(l_out)), -499);
    check("R12 right own", int'($signed(r_out)), 1022);
    strobes(510);
    read_gain(g);
    check("R3 one left", g, 1);
    strobes(1);
    l_in = DATA_W'(-8388608);
    r_in = DATA_W'(8388607);
    @(negedge clk);
    check("R10 left", int'($signed(l_out)), 0);
    check("R10 right", int'($signed(r_out)), 0);
    check("R11 muted", int'(st), 2);
    strobes(5);
    read_gain(g);
    check("R5 floor", g, 0);
  endtask

  task automatic t_up;
    int g;
    mute = 1'b0;
    strobes(GMAX - 1);
    read_gain(g);
    check("R4 almost", g, GMAX - 1);
    strobes(1);
    read_gain(g);
    check("R4 unity", g, GMAX);
    check("R11 unity", int'(st), 0);
  endtask

  task automatic t_reverse;
    int g;
    mute = 1'b1;
    strobes(300);
    read_gain(g);
    check("R6 descended", g, GMAX - 300);
    mute = 1'b0;
    strobes(299);
    read_gain(g);
    check("R6 not yet", g, GMAX - 1);
    strobes(1);
    read_gain(g);
    check("R6 recovered", g, GMAX);
  endtask

  task automatic t_reverse_up;
    int g;
    mute = 1'b1;
    strobes(GMAX);
    mute = 1'b0;
    strobes(200);
    read_gain(g);
    check("R7 climbed", g, 200);
    mute = 1'b1;
    strobes(50);
    read_gain(g);
    check("R7 reversed", g, 150);
    strobes(150);
    read_gain(g);
    check("R7 muted", g, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_unity();
    t_no_strobe();
    t_down();
    t_up();
    t_reverse();
    t_reverse_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule